// File: doc/BRIEF.md
# Memory Dependency Group Tracker

This block keeps a fixed table of memory groups for an out-of-order load/store scheduler. A group collects memory operations that do not depend on one another. Each group counts its predecessor groups in three ways: total, currently executing and fully executed. It also counts its own operations in three ways: total, issued and completed. Two successor masks record which other groups depend on it. The masks for ordering edges and for data edges are kept apart.

The two kinds of edge are released at different times. An ordering edge is released as soon as the predecessor group starts executing, which means every one of its outstanding operations has issued. A data edge counts as executing at that point and is released only when the predecessor has completed every operation. From these counts each group reports registered waiting, pending, ready, executing and executed flags. Each group also reports a critical-predecessor cycle estimate, which counts down while the group waits.

The scheduler sends one command per clock over a valid/ready channel. The scheduler chooses group indices itself; index 0 never names a group. Any command that cannot be honoured raises a one-cycle error pulse and changes no state.

Top module: `mem_dep_tracker`

## Requirements
- R1: `cmd_ready` is low during reset and high from the first clock edge after reset. A command is taken on any edge where `cmd_valid` and `cmd_ready` are both high. Its effects on the flags, the cycle estimates and `err` appear after that edge. `err` is low after any edge that takes no command.
- R2: Command code 1 (create) on an unallocated index from 1 to NG allocates the group with zero counts. It then shows ready and executed only (flags W,P,R,X,D = 00101). Create on an allocated index raises `err`.
- R3: The following raise `err` for exactly one cycle and change no group: an index of 0 or above NG, an unallocated group, or a command code other than 1 to 5.
- R4: A group is waiting when total predecessors exceed executing plus executed predecessors. It is pending when executing predecessors are nonzero and executing plus executed predecessors equal the total. It is ready when executed predecessors equal the total.
- R5: Code 4 (issue) adds one issued operation. A group is executing when issued is nonzero and equals total minus completed. It is executed when completed equals total. Issuing when no operation is outstanding raises `err`. Code 5 (complete) with nothing issued raises `err`.
- R6: When a group becomes executing, each of its ordering successors counts that predecessor as executed at once.
- R7: When a group becomes executing, each of its data successors counts that predecessor as executing. When the group becomes executed, each data successor moves that predecessor from executing to executed.
- R8: Code 3 (link) from `cmd_grp` to `cmd_dst` with `cmd_data`=0 is an ordering edge. If the source is already executing, that edge has no effect and raises no error. A data edge (`cmd_data`=1) from an executing source counts that source as executing at once. Linking from an executed source, linking a group to itself, and linking a duplicate edge all raise `err`.
- R9: Code 2 (add operation) on a group that already has any successor raises `err` and leaves the operation count unchanged.
- R10: A group's cycle estimate on `grp_crit` is raised to the larger of its current value and the issue-cycle value carried by a data predecessor when that predecessor starts executing. The value is that predecessor's largest `cmd_cycles` so far. While the group is waiting, the estimate drops by one per clock and stops at 0.
- R11: An unallocated group shows all flags low. On edges that take no command, no flag changes and no cycle estimate rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle |
| cmd_op | input | 3 | Command code: 1 create, 2 add operation, 3 link, 4 issue, 5 complete |
| cmd_grp | input | IDX_W (4) | Group acted on, or source of a link |
| cmd_dst | input | IDX_W (4) | Successor group of a link |
| cmd_data | input | 1 | Link kind: 1 data, 0 ordering |
| cmd_cycles | input | CYC_W (8) | Remaining cycles of the issued operation |
| err | output | 1 | One-cycle pulse for a rejected command |
| grp_waiting | output | NG (8) | Waiting flag, bit j for group j+1 |
| grp_pending | output | NG (8) | Pending flag per group |
| grp_ready | output | NG (8) | Ready flag per group |
| grp_executing | output | NG (8) | Executing flag per group |
| grp_executed | output | NG (8) | Executed flag per group |
| grp_crit | output | NG*CYC_W (64) | Cycle estimate per group, group j+1 in bits j*CYC_W upward |

## Verification
The bench runs the same dependency function through four patterns.

- An ordering edge from a two-operation group shows that release waits for the last issue, not the first.
- A data edge shows the pending step between issue and completion, which ordering edges never produce.
- Edges added after the source is already executing separate the silently dropped ordering edge from the data edge that is counted at once. In the same scenario, a rejected add-operation is caught by watching when the source finishes.
- Two data predecessors with different cycle values show the estimate counting down to zero and then being raised, and show that it freezes once the group is no longer waiting.

// File: rtl/mdg_pkg.sv
package mdg_pkg;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_CREATE   = 3'd1,
    OP_ADD_INST = 3'd2,
    OP_LINK     = 3'd3,
    OP_ISSUE    = 3'd4,
    OP_COMPLETE = 3'd5
  } mdg_op_e;

  typedef struct packed {
    logic waiting;
    logic pending;
    logic ready;
    logic executing;
    logic executed;
  } mdg_flags_t;

endpackage

// File: rtl/mdg_decode.sv
module mdg_decode
  import mdg_pkg::*;
#(
  parameter int NG    = 8,
  parameter int IDX_W = 4,
  parameter int CNT_W = 4,
  parameter int CYC_W = 8
) (
  input  logic                cmd_fire,
  input  logic [2:0]          cmd_op,
  input  logic [IDX_W-1:0]    cmd_grp,
  input  logic [IDX_W-1:0]    cmd_dst,
  input  logic                cmd_data,
  input  logic [CYC_W-1:0]    cmd_cycles,
  input  logic [NG-1:0]       alloc,
  input  logic [NG*CNT_W-1:0] inst_flat,
  input  logic [NG*CNT_W-1:0] iss_flat,
  input  logic [NG*CNT_W-1:0] done_flat,
  input  logic [NG*NG-1:0]    omask_flat,
  input  logic [NG*NG-1:0]    dmask_flat,
  input  logic [NG*CYC_W-1:0] cinst_flat,
  output logic                err,
  output logic [NG-1:0]       ev_create,
  output logic [NG-1:0]       ev_add_inst,
  output logic [NG-1:0]       ev_issue,
  output logic [NG-1:0]       ev_complete,
  output logic [NG-1:0]       ev_link,
  output logic                link_data,
  output logic [NG-1:0]       link_dst,
  output logic [NG-1:0]       tot_inc,
  output logic [NG-1:0]       exe_inc,
  output logic [NG-1:0]       done_inc,
  output logic [NG-1:0]       exe2done,
  output logic [NG-1:0]       crit_raise,
  output logic [CYC_W-1:0]    crit_val
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NG);

  logic             src_ok, dst_ok;
  logic [IDX_W-1:0] si, di;
  logic             s_alloc, d_alloc;
  logic [CNT_W-1:0] s_inst, s_iss, s_done, s_out;
  logic [NG-1:0]    s_om, s_dm, dst_oh;
  logic [CYC_W-1:0] s_ci;
  logic             s_exec, s_fin;

  always_comb begin
    src_ok  = (cmd_grp != '0) && (cmd_grp <= LAST_IDX);
    dst_ok  = (cmd_dst != '0) && (cmd_dst <= LAST_IDX);
    si      = src_ok ? cmd_grp - IDX_W'(1) : '0;
    di      = dst_ok ? cmd_dst - IDX_W'(1) : '0;
    s_alloc = alloc[si];
    d_alloc = alloc[di];
    s_inst  = inst_flat[si*CNT_W +: CNT_W];
    s_iss   = iss_flat[si*CNT_W +: CNT_W];
    s_done  = done_flat[si*CNT_W +: CNT_W];
    s_om    = omask_flat[si*NG +: NG];
    s_dm    = dmask_flat[si*NG +: NG];
    s_ci    = cinst_flat[si*CYC_W +: CYC_W];
    s_out   = s_inst - s_done;
    s_exec  = (s_iss != '0) && (s_iss == s_out);
    s_fin   = (s_done == s_inst);
    dst_oh  = dst_ok ? (NG'(1) << di) : '0;
  end

  always_comb begin
    err         = 1'b0;
    ev_create   = '0;
    ev_add_inst = '0;
    ev_issue    = '0;
    ev_complete = '0;
    ev_link     = '0;
    link_data   = 1'b0;
    link_dst    = '0;
    tot_inc     = '0;
    exe_inc     = '0;
    done_inc    = '0;
    exe2done    = '0;
    crit_raise  = '0;
    crit_val    = '0;
    if (cmd_fire) begin
      case (cmd_op)
        OP_CREATE: begin
          if (!src_ok || s_alloc) err = 1'b1;
          else ev_create[si] = 1'b1;
        end
        OP_ADD_INST: begin
          if (!src_ok || !s_alloc || ((s_om | s_dm) != '0) || (s_inst == '1)) err = 1'b1;
          else ev_add_inst[si] = 1'b1;
        end
        OP_ISSUE: begin
          if (!src_ok || !s_alloc || (s_iss >= s_out)) err = 1'b1;
          else begin
            ev_issue[si] = 1'b1;
            if (s_iss + CNT_W'(1) == s_out) begin
              done_inc   = s_om;
              exe_inc    = s_dm;
              crit_raise = s_dm;
              crit_val   = (cmd_cycles > s_ci) ? cmd_cycles : s_ci;
            end
          end
        end
        OP_COMPLETE: begin
          if (!src_ok || !s_alloc || (s_iss == '0)) err = 1'b1;
          else begin
            ev_complete[si] = 1'b1;
            if (s_done + CNT_W'(1) == s_inst) exe2done = s_dm;
          end
        end
        OP_LINK: begin
          if (!src_ok || !dst_ok || !s_alloc || !d_alloc || (cmd_grp == cmd_dst) ||
              s_fin || (((s_om | s_dm) & dst_oh) != '0)) err = 1'b1;
          else if (cmd_data || !s_exec) begin
            ev_link[si] = 1'b1;
            link_data   = cmd_data;
            link_dst    = dst_oh;
            tot_inc     = dst_oh;
            if (s_exec) begin
              exe_inc    = dst_oh;
              crit_raise = dst_oh;
              crit_val   = s_ci;
            end
          end
        end
        default: err = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/mdg_group.sv
module mdg_group
  import mdg_pkg::*;
#(
  parameter int NG    = 8,
  parameter int CNT_W = 4,
  parameter int CYC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_create,
  input  logic             ev_add_inst,
  input  logic             ev_issue,
  input  logic             ev_complete,
  input  logic [CYC_W-1:0] issue_cycles,
  input  logic             ev_link,
  input  logic             link_data,
  input  logic [NG-1:0]    link_dst,
  input  logic             pred_tot_inc,
  input  logic             pred_exe_inc,
  input  logic             pred_done_inc,
  input  logic             pred_exe2done,
  input  logic             crit_raise,
  input  logic [CYC_W-1:0] crit_in,
  output logic             alloc,
  output logic [CNT_W-1:0] inst_cnt,
  output logic [CNT_W-1:0] iss_cnt,
  output logic [CNT_W-1:0] done_cnt,
  output logic [NG-1:0]    omask,
  output logic [NG-1:0]    dmask,
  output logic [CYC_W-1:0] crit_inst,
  output logic [CYC_W-1:0] crit_cnt,
  output mdg_flags_t       flags
);

  localparam int SUM_W = CNT_W + 1;

  logic             alloc_d;
  logic [CNT_W-1:0] ptot_q, ptot_d, pexe_q, pexe_d, pdone_q, pdone_d;
  logic [CNT_W-1:0] inst_d, iss_d, done_d;
  logic [NG-1:0]    omask_d, dmask_d;
  logic [CYC_W-1:0] cinst_d, crit_d;
  logic [SUM_W-1:0] started_d;
  mdg_flags_t       flags_d;

  always_comb begin
    alloc_d = alloc;
    ptot_d  = ptot_q;
    pexe_d  = pexe_q;
    pdone_d = pdone_q;
    inst_d  = inst_cnt;
    iss_d   = iss_cnt;
    done_d  = done_cnt;
    omask_d = omask;
    dmask_d = dmask;
    cinst_d = crit_inst;
    crit_d  = crit_cnt;
    if (ev_create) begin
      alloc_d = 1'b1;
      ptot_d  = '0;
      pexe_d  = '0;
      pdone_d = '0;
      inst_d  = '0;
      iss_d   = '0;
      done_d  = '0;
      omask_d = '0;
      dmask_d = '0;
      cinst_d = '0;
      crit_d  = '0;
    end else begin
      if (ev_add_inst) inst_d = inst_cnt + CNT_W'(1);
      if (ev_issue) begin
        iss_d = iss_cnt + CNT_W'(1);
        if (issue_cycles > crit_inst) cinst_d = issue_cycles;
      end
      if (ev_complete) begin
        iss_d  = iss_cnt - CNT_W'(1);
        done_d = done_cnt + CNT_W'(1);
      end
      if (ev_link) begin
        if (link_data) dmask_d = dmask | link_dst;
        else           omask_d = omask | link_dst;
      end
      ptot_d  = ptot_q + CNT_W'(pred_tot_inc);
      pexe_d  = pexe_q + CNT_W'(pred_exe_inc) - CNT_W'(pred_exe2done);
      pdone_d = pdone_q + CNT_W'(pred_done_inc) + CNT_W'(pred_exe2done);
      if (crit_raise && (crit_in > crit_cnt)) crit_d = crit_in;
      else if (flags.waiting && (crit_cnt != '0)) crit_d = crit_cnt - CYC_W'(1);
    end
  end

  always_comb begin
    started_d         = SUM_W'(pexe_d) + SUM_W'(pdone_d);
    flags_d.waiting   = alloc_d && (SUM_W'(ptot_d) > started_d);
    flags_d.pending   = alloc_d && (pexe_d != '0) && (SUM_W'(ptot_d) == started_d);
    flags_d.ready     = alloc_d && (pdone_d == ptot_d);
    flags_d.executing = alloc_d && (iss_d != '0) && (iss_d == inst_d - done_d);
    flags_d.executed  = alloc_d && (done_d == inst_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alloc     <= 1'b0;
      ptot_q    <= '0;
      pexe_q    <= '0;
      pdone_q   <= '0;
      inst_cnt  <= '0;
      iss_cnt   <= '0;
      done_cnt  <= '0;
      omask     <= '0;
      dmask     <= '0;
      crit_inst <= '0;
      crit_cnt  <= '0;
      flags     <= '0;
    end else begin
      alloc     <= alloc_d;
      ptot_q    <= ptot_d;
      pexe_q    <= pexe_d;
      pdone_q   <= pdone_d;
      inst_cnt  <= inst_d;
      iss_cnt   <= iss_d;
      done_cnt  <= done_d;
      omask     <= omask_d;
      dmask     <= dmask_d;
      crit_inst <= cinst_d;
      crit_cnt  <= crit_d;
      flags     <= flags_d;
    end
  end

endmodule

// File: rtl/mem_dep_tracker.sv
module mem_dep_tracker
  import mdg_pkg::*;
#(
  parameter int NG    = 8,
  parameter int CNT_W = 4,
  parameter int CYC_W = 8,
  localparam int IDX_W = $clog2(NG + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [2:0]          cmd_op,
  input  logic [IDX_W-1:0]    cmd_grp,
  input  logic [IDX_W-1:0]    cmd_dst,
  input  logic                cmd_data,
  input  logic [CYC_W-1:0]    cmd_cycles,
  output logic                err,
  output logic [NG-1:0]       grp_waiting,
  output logic [NG-1:0]       grp_pending,
  output logic [NG-1:0]       grp_ready,
  output logic [NG-1:0]       grp_executing,
  output logic [NG-1:0]       grp_executed,
  output logic [NG*CYC_W-1:0] grp_crit
);

  logic                cmd_fire;
  logic                err_d;
  logic [NG-1:0]       alloc;
  logic [NG*CNT_W-1:0] inst_flat, iss_flat, done_flat;
  logic [NG*NG-1:0]    omask_flat, dmask_flat;
  logic [NG*CYC_W-1:0] cinst_flat;
  logic [NG-1:0]       ev_create, ev_add_inst, ev_issue, ev_complete, ev_link;
  logic                link_data;
  logic [NG-1:0]       link_dst;
  logic [NG-1:0]       tot_inc, exe_inc, done_inc, exe2done, crit_raise;
  logic [CYC_W-1:0]    crit_val;
  mdg_flags_t          flags [NG];

  assign cmd_fire = cmd_valid && cmd_ready;

  mdg_decode #(.NG(NG), .IDX_W(IDX_W), .CNT_W(CNT_W), .CYC_W(CYC_W)) u_dec (
    .cmd_fire   (cmd_fire),
    .cmd_op     (cmd_op),
    .cmd_grp    (cmd_grp),
    .cmd_dst    (cmd_dst),
    .cmd_data   (cmd_data),
    .cmd_cycles (cmd_cycles),
    .alloc      (alloc),
    .inst_flat  (inst_flat),
    .iss_flat   (iss_flat),
    .done_flat  (done_flat),
    .omask_flat (omask_flat),
    .dmask_flat (dmask_flat),
    .cinst_flat (cinst_flat),
    .err        (err_d),
    .ev_create  (ev_create),
    .ev_add_inst(ev_add_inst),
    .ev_issue   (ev_issue),
    .ev_complete(ev_complete),
    .ev_link    (ev_link),
    .link_data  (link_data),
    .link_dst   (link_dst),
    .tot_inc    (tot_inc),
    .exe_inc    (exe_inc),
    .done_inc   (done_inc),
    .exe2done   (exe2done),
    .crit_raise (crit_raise),
    .crit_val   (crit_val)
  );

  for (genvar j = 0; j < NG; j++) begin : g_grp
    mdg_group #(.NG(NG), .CNT_W(CNT_W), .CYC_W(CYC_W)) u_grp (
      .clk          (clk),
      .rst_n        (rst_n),
      .ev_create    (ev_create[j]),
      .ev_add_inst  (ev_add_inst[j]),
      .ev_issue     (ev_issue[j]),
      .ev_complete  (ev_complete[j]),
      .issue_cycles (cmd_cycles),
      .ev_link      (ev_link[j]),
      .link_data    (link_data),
      .link_dst     (link_dst),
      .pred_tot_inc (tot_inc[j]),
      .pred_exe_inc (exe_inc[j]),
      .pred_done_inc(done_inc[j]),
      .pred_exe2done(exe2done[j]),
      .crit_raise   (crit_raise[j]),
      .crit_in      (crit_val),
      .alloc        (alloc[j]),
      .inst_cnt     (inst_flat[j*CNT_W +: CNT_W]),
      .iss_cnt      (iss_flat[j*CNT_W +: CNT_W]),
      .done_cnt     (done_flat[j*CNT_W +: CNT_W]),
      .omask        (omask_flat[j*NG +: NG]),
      .dmask        (dmask_flat[j*NG +: NG]),
      .crit_inst    (cinst_flat[j*CYC_W +: CYC_W]),
      .crit_cnt     (grp_crit[j*CYC_W +: CYC_W]),
      .flags        (flags[j])
    );
    assign grp_waiting[j]   = flags[j].waiting;
    assign grp_pending[j]   = flags[j].pending;
    assign grp_ready[j]     = flags[j].ready;
    assign grp_executing[j] = flags[j].executing;
    assign grp_executed[j]  = flags[j].executed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_ready <= 1'b0;
      err       <= 1'b0;
    end else begin
      cmd_ready <= 1'b1;
      err       <= err_d;
    end
  end

endmodule

// File: rtl/mdg_tracker_chk.sv
module mdg_tracker_chk #(
  parameter int NG    = 8,
  parameter int CYC_W = 8,
  parameter int IDX_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic                cmd_ready,
  input logic [2:0]          cmd_op,
  input logic [IDX_W-1:0]    cmd_grp,
  input logic                err,
  input logic [NG-1:0]       grp_waiting,
  input logic [NG-1:0]       grp_pending,
  input logic [NG-1:0]       grp_ready,
  input logic [NG-1:0]       grp_executing,
  input logic [NG-1:0]       grp_executed,
  input logic [NG*CYC_W-1:0] grp_crit
);

  a_r1_err_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_ready) |=> !err);

  a_r3_zero_index: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_grp == '0) |=> err);

  for (genvar j = 0; j < NG; j++) begin : g_chk
    a_r4_one_wait_state: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({grp_waiting[j], grp_pending[j], grp_ready[j]}));

    a_r5_exec_not_done: assert property (@(posedge clk) disable iff (!rst_n)
      !(grp_executing[j] && grp_executed[j]));

    a_r2_create_fresh: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && cmd_op == 3'd1 && cmd_grp == IDX_W'(j + 1))
      |=> (err || (grp_ready[j] && grp_executed[j] && !grp_waiting[j])));

    a_r11_idle_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && cmd_ready) |=> $stable({grp_waiting[j], grp_pending[j], grp_ready[j],
                                              grp_executing[j], grp_executed[j]}));

    a_r10_idle_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && cmd_ready) |=> (grp_crit[j*CYC_W +: CYC_W] <= $past(grp_crit[j*CYC_W +: CYC_W])));
  end

endmodule

bind mem_dep_tracker mdg_tracker_chk #(.NG(NG), .CYC_W(CYC_W), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_op       (cmd_op),
  .cmd_grp      (cmd_grp),
  .err          (err),
  .grp_waiting  (grp_waiting),
  .grp_pending  (grp_pending),
  .grp_ready    (grp_ready),
  .grp_executing(grp_executing),
  .grp_executed (grp_executed),
  .grp_crit     (grp_crit)
);

// File: tb/mem_dep_tracker_test.sv
module mem_dep_tracker_test;

  localparam int CLK_PERIOD = 10;
  localparam int NG    = 8;
  localparam int CNT_W = 4;
  localparam int CYC_W = 8;
  localparam int IDX_W = 4;

  localparam logic [2:0] C_CREATE = 3'd1;
  localparam logic [2:0] C_ADD    = 3'd2;
  localparam logic [2:0] C_LINK   = 3'd3;
  localparam logic [2:0] C_ISSUE  = 3'd4;
  localparam logic [2:0] C_DONE   = 3'd5;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                cmd_valid = 1'b0;
  logic                cmd_ready;
  logic [2:0]          cmd_op = '0;
  logic [IDX_W-1:0]    cmd_grp = '0;
  logic [IDX_W-1:0]    cmd_dst = '0;
  logic                cmd_data = 1'b0;
  logic [CYC_W-1:0]    cmd_cycles = '0;
  logic                err;
  logic [NG-1:0]       grp_waiting, grp_pending, grp_ready, grp_executing, grp_executed;
  logic [NG*CYC_W-1:0] grp_crit;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_dep_tracker #(.NG(NG), .CNT_W(CNT_W), .CYC_W(CYC_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_grp(cmd_grp), .cmd_dst(cmd_dst), .cmd_data(cmd_data),
    .cmd_cycles(cmd_cycles), .err(err), .grp_waiting(grp_waiting),
    .grp_pending(grp_pending), .grp_ready(grp_ready), .grp_executing(grp_executing),
    .grp_executed(grp_executed), .grp_crit(grp_crit)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // flags of group g (1-based) as W,P,R,X,D
  function automatic logic [4:0] fl(input int g);
    return {grp_waiting[g-1], grp_pending[g-1], grp_ready[g-1],
            grp_executing[g-1], grp_executed[g-1]};
  endfunction

  function automatic logic [CYC_W-1:0] crit(input int g);
    return grp_crit[(g-1)*CYC_W +: CYC_W];
  endfunction

  task automatic send(input logic [2:0] op, input int g, input int d, input logic dk, input int cyc);
    @(negedge clk);
    cmd_valid  = 1'b1;
    cmd_op     = op;
    cmd_grp    = g[IDX_W-1:0];
    cmd_dst    = d[IDX_W-1:0];
    cmd_data   = dk;
    cmd_cycles = cyc[CYC_W-1:0];
    @(negedge clk);
    cmd_valid  = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic t_reset;
    do_reset();
    check("R1 ready after reset", {31'd0, cmd_ready}, 32'd1);
    check("R1 err idle", {31'd0, err}, 32'd0);
    check("R11 all flags low", {grp_waiting, grp_pending, grp_ready, grp_executing, grp_executed}, 32'd0);
    check("R11 crit zero", grp_crit[31:0], 32'd0);
  endtask

  task automatic t_create_errors;
    do_reset();
    send(C_CREATE, 1, 0, 1'b0, 0);
    check("R2 create ok", {31'd0, err}, 32'd0);
    check("R2 fresh flags", {27'd0, fl(1)}, 32'h05);
    send(C_CREATE, 1, 0, 1'b0, 0);
    check("R2 double create", {31'd0, err}, 32'd1);
    idle(1);
    check("R3 err one cycle", {31'd0, err}, 32'd0);
    send(C_CREATE, 0, 0, 1'b0, 0);
    check("R3 index zero", {31'd0, err}, 32'd1);
    send(C_CREATE, 9, 0, 1'b0, 0);
    check("R3 index above range", {31'd0, err}, 32'd1);
    send(C_ADD, 2, 0, 1'b0, 0);
    check("R3 unallocated", {31'd0, err}, 32'd1);
    check("R11 unallocated flags", {27'd0, fl(2)}, 32'd0);
    send(3'd7, 1, 0, 1'b0, 0);
    check("R3 bad code", {31'd0, err}, 32'd1);
    check("R3 group untouched", {27'd0, fl(1)}, 32'h05);
  endtask

  task automatic t_order;
    do_reset();
    send(C_CREATE, 1, 0, 1'b0, 0);
    send(C_CREATE, 2, 0, 1'b0, 0);
    send(C_ADD, 1, 0, 1'b0, 0);
    send(C_ADD, 1, 0, 1'b0, 0);
    send(C_ADD, 2, 0, 1'b0, 0);
    send(C_LINK, 1, 2, 1'b0, 0);
    check("R4 succ waiting", {27'd0, fl(2)}, 32'h10);
    check("R4 src ready", {27'd0, fl(1)}, 32'h04);
    send(C_ISSUE, 1, 0, 1'b0, 4);
    check("R5 partial issue not executing", {27'd0, fl(1)}, 32'h04);
    check("R6 held until last issue", {27'd0, fl(2)}, 32'h10);
    send(C_ISSUE, 1, 0, 1'b0, 4);
    check("R5 executing", {27'd0, fl(1)}, 32'h06);
    check("R6 order release", {27'd0, fl(2)}, 32'h04);
    send(C_ISSUE, 1, 0, 1'b0, 4);
    check("R5 over issue", {31'd0, err}, 32'd1);
    send(C_DONE, 1, 0, 1'b0, 0);
    check("R5 one done still executing", {27'd0, fl(1)}, 32'h06);
    send(C_DONE, 1, 0, 1'b0, 0);
    check("R5 executed", {27'd0, fl(1)}, 32'h05);
    send(C_DONE, 1, 0, 1'b0, 0);
    check("R5 complete nothing issued", {31'd0, err}, 32'd1);
  endtask

  task automatic t_data;
    do_reset();
    send(C_CREATE, 1, 0, 1'b0, 0);
    send(C_CREATE, 2, 0, 1'b0, 0);
    send(C_ADD, 1, 0, 1'b0, 0);
    send(C_ADD, 2, 0, 1'b0, 0);
    send(C_LINK, 1, 2, 1'b1, 0);
    check("R4 data succ waiting", {27'd0, fl(2)}, 32'h10);
    send(C_LINK, 1, 2, 1'b0, 0);
    check("R8 duplicate edge", {31'd0, err}, 32'd1);
    send(C_LINK, 2, 2, 1'b1, 0);
    check("R8 self edge", {31'd0, err}, 32'd1);
    send(C_ISSUE, 1, 0, 1'b0, 2);
    check("R7 pending on issue", {27'd0, fl(2)}, 32'h08);
    send(C_DONE, 1, 0, 1'b0, 0);
    check("R7 ready on completion", {27'd0, fl(2)}, 32'h04);
    check("R7 src executed", {27'd0, fl(1)}, 32'h05);
    send(C_LINK, 1, 2, 1'b1, 0);
    check("R8 link from executed", {31'd0, err}, 32'd1);
  endtask

  task automatic t_late_edges;
    do_reset();
    send(C_CREATE, 1, 0, 1'b0, 0);
    send(C_CREATE, 2, 0, 1'b0, 0);
    send(C_CREATE, 3, 0, 1'b0, 0);
    send(C_ADD, 1, 0, 1'b0, 0);
    send(C_ISSUE, 1, 0, 1'b0, 6);
    check("R5 single op executing", {27'd0, fl(1)}, 32'h06);
    send(C_LINK, 1, 2, 1'b0, 0);
    check("R8 late order no err", {31'd0, err}, 32'd0);
    check("R8 late order ignored", {27'd0, fl(2)}, 32'h05);
    send(C_LINK, 1, 3, 1'b1, 0);
    check("R8 late data pending", {27'd0, fl(3)}, 32'h09);
    send(C_ADD, 1, 0, 1'b0, 0);
    check("R9 add with successor", {31'd0, err}, 32'd1);
    send(C_DONE, 1, 0, 1'b0, 0);
    check("R9 count unchanged", {27'd0, fl(1)}, 32'h05);
    check("R7 late data released", {27'd0, fl(3)}, 32'h05);
  endtask

  task automatic t_crit;
    do_reset();
    send(C_CREATE, 1, 0, 1'b0, 0);
    send(C_CREATE, 2, 0, 1'b0, 0);
    send(C_CREATE, 3, 0, 1'b0, 0);
    send(C_ADD, 1, 0, 1'b0, 0);
    send(C_ADD, 2, 0, 1'b0, 0);
    send(C_LINK, 1, 3, 1'b1, 0);
    send(C_LINK, 2, 3, 1'b1, 0);
    check("R4 two preds waiting", {27'd0, fl(3)}, 32'h11);
    send(C_ISSUE, 1, 0, 1'b0, 3);
    check("R10 raised", {24'd0, crit(3)}, 32'd3);
    idle(1);
    check("R10 counts down", {24'd0, crit(3)}, 32'd2);
    idle(5);
    check("R10 stops at zero", {24'd0, crit(3)}, 32'd0);
    send(C_ISSUE, 2, 0, 1'b0, 9);
    check("R10 raised by second pred", {24'd0, crit(3)}, 32'd9);
    check("R7 pending both executing", {27'd0, fl(3)}, 32'h09);
    idle(2);
    check("R10 frozen when not waiting", {24'd0, crit(3)}, 32'd9);
  endtask

  initial begin
    t_reset();
    t_create_errors();
    t_order();
    t_data();
    t_late_edges();
    t_crit();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule